// File: doc/BRIEF.md
# Pushbutton Press Conditioner

This block turns the raw contact of a mechanical pushbutton into two clean signals. In a slow sampling domain (a tick of roughly 100 Hz in a real system) the raw input is first passed through a synchronizer and then fed into a short shift register. The debounced level moves only when every sample held in that register agrees. The button and the debounced level are both active-low: low means pressed. Once a press has been registered the level stays low until a release has been registered in the same way.

A second stage runs on the system clock, which is the clock that drives the state machine consuming the button. It brings the debounced level across into that domain through a synchronizer and then emits a pulse exactly one system cycle wide on every press edge, which is the falling edge of the level. Holding the button down does not produce any further pulses, and releasing it produces none.

Both stages share one synchronous reset. This reset must be held across several edges of each clock. It forces the level to the released state and clears the pulse.

Top module: `press_conditioner`

## Requirements
- R1: While reset is held, `btn_level_n` is 1 (released) and `press_pulse` is 0.
- R2: `btn_level_n` takes a new value only at a sample edge where the last AGREE_DEPTH (default 4) synchronized samples all equal that value. Four consecutive low samples are enough to register a press.
- R3: When `btn_raw` is held at a new value starting before sample edge 1, `btn_level_n` still shows the old value after sample edge 6 and shows the new value after sample edge 7. This is SYNC_STAGES + AGREE_DEPTH + 1 edges with the defaults.
- R4: A low excursion of `btn_raw` lasting fewer than AGREE_DEPTH sample edges leaves `btn_level_n` at 1 and produces no pulse.
- R5: Once low, `btn_level_n` stays low for as long as the button is held low.
- R6: Each 1-to-0 transition of `btn_level_n` yields exactly one `press_pulse`, and that pulse lasts exactly one `sys_clk` cycle, however long the press lasts.
- R7: `press_pulse` never rises on a release (0-to-1 of the level). It is only high while the synchronized level is low.
- R8: The pulse follows the level's falling edge within 6 `sys_clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sample_clk | input | 1 | Slow sampling clock for the debounce filter |
| sys_clk | input | 1 | System clock of the consuming state machine |
| rst | input | 1 | Synchronous reset, active high, held across edges of both clocks |
| btn_raw | input | 1 | Raw button contact, low when pressed, asynchronous |
| btn_level_n | output | 1 | Debounced level in the sample domain, low while pressed |
| press_pulse | output | 1 | One `sys_clk` cycle pulse per registered press |

## Verification
The properties assume three things about the inputs. First, reset is held long enough to reach both domains. Second, the system clock is much faster than the sample clock, so any debounced level lasts many system cycles and a synchronized low level is still low when its pulse appears. Third, the raw input is not aligned to the sample clock. The bench drives the raw input only on falling edges of the sample clock, and it uses clock periods that are not multiples of each other (36.6 ns against 4 ns). Each random bounce burst is followed by a stable stretch of at least eight samples, so the filter always settles before the next burst begins.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  // True when the low n bits of v are all ones or all zeros.
  function automatic logic lanes_agree(input logic [31:0] v, input int unsigned n);
    logic ones;
    logic zeros;
    ones  = 1'b1;
    zeros = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (i < n) begin
        ones  = ones & v[i];
        zeros = zeros & ~v[i];
      end
    end
    return ones | zeros;
  endfunction

  // Sample edges from a raw change until the level shows it.
  function automatic int unsigned settle_edges(input int unsigned sync_n, input int unsigned depth);
    return sync_n + depth + 1;
  endfunction

endpackage

// File: rtl/pbc_sync_chain.sv
module pbc_sync_chain #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pbc_agree_filter.sv
module pbc_agree_filter
  import pbc_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sample,
  output logic level,
  output logic agree
);
  logic [DEPTH-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) hist <= {DEPTH{1'b1}};
    else     hist <= {hist[DEPTH-2:0], sample};
  end

  assign agree = lanes_agree(32'(hist), DEPTH);

  always_ff @(posedge clk) begin
    if (rst)        level <= 1'b1;
    else if (agree) level <= hist[0];
  end
endmodule

// File: rtl/pbc_fall_pulse.sv
module pbc_fall_pulse (
  input  logic clk,
  input  logic rst,
  input  logic level_n,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      pulse  <= 1'b0;
    end else begin
      prev_q <= level_n;
      pulse  <= prev_q & ~level_n;
    end
  end
endmodule

// File: rtl/press_conditioner.sv
module press_conditioner
  import pbc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned AGREE_DEPTH = 4
) (
  input  logic sample_clk,
  input  logic sys_clk,
  input  logic rst,
  input  logic btn_raw,
  output logic btn_level_n,
  output logic press_pulse
);
  localparam int unsigned SETTLE = settle_edges(SYNC_STAGES, AGREE_DEPTH);

  logic raw_synced;
  logic filt_agree;
  logic lvl_sys;

  pbc_sync_chain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_raw_sync (
    .clk(sample_clk), .rst(rst), .d(btn_raw), .q(raw_synced)
  );

  pbc_agree_filter #(.DEPTH(AGREE_DEPTH)) u_filter (
    .clk(sample_clk), .rst(rst), .sample(raw_synced),
    .level(btn_level_n), .agree(filt_agree)
  );

  pbc_sync_chain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_lvl_sync (
    .clk(sys_clk), .rst(rst), .d(btn_level_n), .q(lvl_sys)
  );

  pbc_fall_pulse u_pulse (
    .clk(sys_clk), .rst(rst), .level_n(lvl_sys), .pulse(press_pulse)
  );

  initial begin
    if (SETTLE < 3) $error("settle window too short");
  end
endmodule

// File: rtl/press_conditioner_chk.sv
module press_conditioner_chk (
  input logic sample_clk,
  input logic sys_clk,
  input logic rst,
  input logic btn_level_n,
  input logic press_pulse,
  input logic filt_agree,
  input logic lvl_sys
);
  // R1
  reset_pulse_clear_chk: assert property (@(posedge sys_clk)
    $past(rst) |-> !press_pulse);

  // R1
  reset_level_high_chk: assert property (@(posedge sample_clk)
    $past(rst) |-> btn_level_n);

  // R2
  change_needs_agree_chk: assert property (@(posedge sample_clk) disable iff (rst)
    (btn_level_n != $past(btn_level_n)) |-> $past(filt_agree));

  // R6
  single_cycle_pulse_chk: assert property (@(posedge sys_clk) disable iff (rst)
    press_pulse |=> !press_pulse);

  // R7
  pulse_while_low_chk: assert property (@(posedge sys_clk) disable iff (rst)
    press_pulse |-> !lvl_sys);
endmodule

bind press_conditioner press_conditioner_chk u_chk (
  .sample_clk(sample_clk), .sys_clk(sys_clk), .rst(rst),
  .btn_level_n(btn_level_n), .press_pulse(press_pulse),
  .filt_agree(filt_agree), .lvl_sys(lvl_sys)
);

// File: tb/press_conditioner_tb.sv
`timescale 1ns/1ps
module press_conditioner_tb;
  logic sample_clk = 1'b0;
  logic sys_clk = 1'b0;
  logic rst = 1'b1;
  logic btn_raw = 1'b1;
  logic btn_level_n;
  logic press_pulse;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  int falls = 0;
  int wait_ctr = 0;
  logic prev_lvl = 1'b1;
  logic prev_pulse = 1'b0;
  int sys_cycles = 0;
  bit done = 0;

  always #2 sys_clk = ~sys_clk;
  always #18.3 sample_clk = ~sample_clk;

  press_conditioner u_dut (
    .sample_clk(sample_clk), .sys_clk(sys_clk), .rst(rst),
    .btn_raw(btn_raw), .btn_level_n(btn_level_n), .press_pulse(press_pulse)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Level expected after holding val for hold edges, starting from prev.
  function automatic logic expect_level(input int hold, input logic prev, input logic val);
    return (hold >= 7) ? val : prev;
  endfunction

  // Call at a sample negedge; returns at a negedge after n sample posedges.
  task automatic drive(input logic val, input int n);
    btn_raw = val;
    repeat (n) @(negedge sample_clk);
  endtask

  // Monitor in the system domain.
  always @(negedge sys_clk) begin
    sys_cycles++;
    if (!rst) begin
      if (prev_lvl && !btn_level_n) begin
        falls++;
        wait_ctr = 1;
      end else if (wait_ctr != 0) begin
        wait_ctr++;
      end
      if (press_pulse) begin
        pulses++;
        check(wait_ctr != 0, "R7 pulse without press edge", 1, 0);
        check(!prev_pulse, "R6 pulse width", 2, 1);
        wait_ctr = 0;
      end
      if (wait_ctr > 6) begin
        check(0, "R8 pulse latency", wait_ctr, 6);
        wait_ctr = 0;
      end
      prev_lvl = btn_level_n;
      prev_pulse = press_pulse;
    end else begin
      prev_lvl = 1'b1;
      prev_pulse = 1'b0;
    end
    if (sys_cycles >= 200000 && !done) begin
      done = 1;
      check(0, "watchdog expired", sys_cycles, 200000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic cur;
    void'($urandom(32'd2024));
    repeat (10) @(negedge sample_clk);
    // R1
    check(btn_level_n == 1'b1, "R1 level in reset", btn_level_n, 1);
    check(press_pulse == 1'b0, "R1 pulse in reset", press_pulse, 0);
    rst = 1'b0;
    repeat (3) @(negedge sample_clk);

    // R3 latency boundary
    drive(1'b0, 6);
    check(btn_level_n == 1'b1, "R3 level after 6 edges", btn_level_n, 1);
    drive(1'b0, 1);
    check(btn_level_n == 1'b0, "R3 level after 7 edges", btn_level_n, 0);

    // R5 long hold, R6 exactly one pulse
    drive(1'b0, 30);
    check(btn_level_n == 1'b0, "R5 level held low", btn_level_n, 0);
    check(pulses == 1, "R6 one pulse for long press", pulses, 1);

    // R7 release gives no pulse
    drive(1'b1, 12);
    check(btn_level_n == 1'b1, "R7 level released", btn_level_n, 1);
    check(pulses == 1, "R7 no pulse on release", pulses, 1);

    // R4 three-sample glitch ignored
    drive(1'b0, 3);
    drive(1'b1, 15);
    check(btn_level_n == 1'b1, "R4 glitch level", btn_level_n, 1);
    check(falls == 1 && pulses == 1, "R4 glitch no pulse", pulses, 1);

    // R2 four agreeing samples are enough
    drive(1'b0, 4);
    drive(1'b1, 3);
    check(btn_level_n == 1'b0, "R2 four samples register", btn_level_n, 0);
    drive(1'b1, 12);
    check(pulses == 2, "R6 pulse for short press", pulses, 2);

    // Random bounce bursts followed by stable stretches
    cur = btn_level_n;
    for (int r = 0; r < 24; r++) begin
      int blen;
      int hold;
      logic val;
      blen = 1 + int'($urandom % 8);
      for (int b = 0; b < blen; b++) drive(1'($urandom % 2), 1);
      val = 1'($urandom % 2);
      hold = 8 + int'($urandom % 13);
      drive(val, hold);
      cur = expect_level(hold, cur, val);
      check(btn_level_n == cur, "R2 settled level", btn_level_n, cur);
    end
    drive(1'b1, 12);
    repeat (10) @(negedge sys_clk);
    check(pulses == falls, "R6 pulses match presses", pulses, falls);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule